// File: doc/BRIEF.md
# DMA Channel Transfer Sequencer

This block is the engine of one DMA channel. Software-side logic arms it with a configuration word, a source start address, a destination start address, a block byte count, a repeat count and an optional acknowledge address and value. After arming, each pulse on the hardware request input starts a burst of beats on a simple memory-style master port. Each beat is a read from the source pointer followed by a write of the returned data to the destination pointer.

The two pointers move independently. Each can stay fixed, count up or count down, with its own step of 1, 2, 4 or 8 bytes. A trigger-mode field sets how much one request moves: a single buffer, a whole block, or the block repeated a set number of times, with both pointers rewound at the start of each pass. When the requesting peripheral has no hardware acknowledge, the engine ends each serviced request with a 32-bit write of a programmed value to a programmed address. Otherwise it pulses an acknowledge output. The channel priority is held for an external arbiter.

Top module: `dma_chan_seq`

## Requirements
- R1: Configuration bits [1:0] control the source pointer and bits [3:2] control the destination pointer. 10 adds the step after every beat, 11 subtracts it, and 00 (or 01) leaves the pointer unchanged.
- R2: Bits [9:8] give the source step and bits [11:10] give the destination step, where codes 00/01/10/11 mean 1/2/4/8 bytes. A beat moves as many bytes as the source step (`mem_bytes_o`), clipped by the bytes left in the buffer and in the block.
- R3: Bits [25:18] hold the buffer length in bytes. `buf_done_o` pulses for one cycle each time a buffer's bytes have all been written, and also when a block ends partway through a buffer.
- R4: Trigger mode bits [29:28] = 00: each request moves one buffer. The block continues over later requests, and the transfer completes when the block count reaches zero.
- R5: Trigger mode 01: one request moves the whole block.
- R6: Trigger mode 10: one request moves the block (repeat count + 1) times. Both pointers and the byte count reload from their start values at the start of each pass, and `blk_done_o` pulses once per pass.
- R7: Arming with a buffer length of 0 or above 128, a block count of 0, or trigger mode 11 sets `err_o`. It stays set until reset, and no memory access is made afterwards.
- R8: With `ack_by_write_i` = 1, each serviced request ends with a write of `ack_val_i` (4 bytes, zero-extended) to `ack_addr_i`. With it at 0, `hw_ack_o` pulses for one cycle instead.
- R9: `busy_o` stays high from the cycle after an accepted request until the last write of that request completes, including the acknowledge write. Requests that arrive while busy are ignored.
- R10: The block byte count drops by each beat's size. `blk_done_o` pulses when it reaches zero, and no beat ever runs past it.
- R11: `prio_o` holds the priority latched at the last accepted arm.
- R12: `xfer_done_o` pulses for one cycle with the last block's `blk_done_o`. The channel then disarms (`armed_o` = 0) and ignores requests until armed again.
- R13: A memory request keeps its address, byte count and write data stable until `mem_ready_i` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| arm_i | input | 1 | Latch the configuration and arm the channel |
| cfg_i | input | 32 | Channel configuration word |
| prio_i | input | 2 | Channel priority to latch on arm |
| src_i | input | AW | Source start address |
| dst_i | input | AW | Destination start address |
| blk_bytes_i | input | CW | Block length in bytes |
| rpt_i | input | RW | Extra passes in repeated-block mode |
| ack_by_write_i | input | 1 | 1: acknowledge by a memory write |
| ack_addr_i | input | AW | Acknowledge write address |
| ack_val_i | input | 32 | Acknowledge write value |
| dreq_i | input | 1 | Hardware request pulse |
| mem_req_o | output | 1 | Memory access request |
| mem_we_o | output | 1 | 1 = write, 0 = read |
| mem_addr_o | output | AW | Access address |
| mem_bytes_o | output | 4 | Bytes in this access (1 to 8) |
| mem_wdata_o | output | DW | Write data |
| mem_rdata_i | input | DW | Read data, valid with ready |
| mem_ready_i | input | 1 | Access completes this cycle |
| busy_o | output | 1 | Servicing a request |
| armed_o | output | 1 | Channel holds a live transfer |
| prio_o | output | 2 | Latched priority |
| hw_ack_o | output | 1 | Hardware acknowledge pulse |
| buf_done_o | output | 1 | Buffer complete pulse |
| blk_done_o | output | 1 | Block complete pulse |
| xfer_done_o | output | 1 | Whole transfer complete pulse |
| err_o | output | 1 | Sticky configuration error |

## Verification
The bench builds the block with AW=32, DW=64, CW=12 and RW=4. A 12-bit block count and a 4-bit repeat count keep every block and repeat sequence short enough to log each beat, yet they still allow non-multiple block sizes, so the clipped final beat comes up. The 64-bit data path makes every step size up to 8 bytes reachable, and the bench's memory returns data derived from the read address, which shows that each write carries the source pointer that produced it. The repeated-block run is made with the ready input stalling every other cycle.

// File: rtl/dma_seq_pkg.sv
`timescale 1ns/1ps
package dma_seq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE, ST_ARMED, ST_RD, ST_WR, ST_ACK
  } seq_st_e;

  localparam logic [1:0] TRIG_BUF = 2'b00;
  localparam logic [1:0] TRIG_BLK = 2'b01;
  localparam logic [1:0] TRIG_RPT = 2'b10;
  localparam logic [1:0] TRIG_LL  = 2'b11;
  localparam logic [7:0] BUF_MAX  = 8'd128;

  // step code to byte count: 0->1, 1->2, 2->4, 3->8
  function automatic logic [3:0] size_bytes(input logic [1:0] code);
    return 4'd1 << code;
  endfunction

  // pointer update: mode 10 adds, 11 subtracts, else holds
  function automatic logic [63:0] ptr_step(input logic [63:0] p,
                                           input logic [1:0] mode,
                                           input logic [1:0] code);
    logic [63:0] s;
    s = 64'(size_bytes(code));
    case (mode)
      2'b10:   return p + s;
      2'b11:   return p - s;
      default: return p;
    endcase
  endfunction

  // bytes of the next beat: smallest of step, buffer left, block left
  function automatic logic [3:0] beat_len(input logic [3:0] sz,
                                          input logic [31:0] buf_left,
                                          input logic [31:0] blk_left);
    logic [31:0] b;
    b = 32'(sz);
    if (buf_left < b) b = buf_left;
    if (blk_left < b) b = blk_left;
    return b[3:0];
  endfunction

endpackage

// File: rtl/dma_ptr_unit.sv
`timescale 1ns/1ps
module dma_ptr_unit
  import dma_seq_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_i,
  input  logic [AW-1:0] start_i,
  input  logic [1:0]    mode_i,
  input  logic [1:0]    size_i,
  input  logic          rewind_i,
  input  logic          step_i,
  output logic [AW-1:0] ptr_o
);

  logic [AW-1:0] start_q, ptr_q;
  logic [1:0]    mode_q, size_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start_q <= '0;
      ptr_q   <= '0;
      mode_q  <= '0;
      size_q  <= '0;
    end else if (load_i) begin
      start_q <= start_i;
      ptr_q   <= start_i;
      mode_q  <= mode_i;
      size_q  <= size_i;
    end else if (rewind_i) begin
      ptr_q <= start_q;
    end else if (step_i) begin
      ptr_q <= AW'(ptr_step(64'(ptr_q), mode_q, size_q));
    end
  end

  assign ptr_o = ptr_q;

  // a pointer in a non-moving mode never changes on a beat
  assert_fixed_ptr_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (step_i && !load_i && !rewind_i && !mode_q[1]) |=> $stable(ptr_o));

endmodule

// File: rtl/dma_len_ctrl.sv
`timescale 1ns/1ps
module dma_len_ctrl
  import dma_seq_pkg::*;
#(
  parameter int CW = 17,
  parameter int RW = 8,
  parameter int LW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_i,
  input  logic [CW-1:0] blk_i,
  input  logic [LW-1:0] buf_len_i,
  input  logic [RW-1:0] rpt_i,
  input  logic [1:0]    src_size_i,
  input  logic          beat_i,
  input  logic          buf_rl_i,
  input  logic          blk_rl_i,
  output logic [3:0]    beat_bytes_o,
  output logic          buf_end_o,
  output logic          blk_end_o,
  output logic          rpt_zero_o
);

  logic [CW-1:0] blk_q, blk_start_q;
  logic [LW-1:0] buf_q, buf_len_q;
  logic [RW-1:0] rpt_q;
  logic [1:0]    sz_q;

  assign beat_bytes_o = beat_len(size_bytes(sz_q), 32'(buf_q), 32'(blk_q));
  assign buf_end_o    = (buf_q == LW'(beat_bytes_o));
  assign blk_end_o    = (blk_q == CW'(beat_bytes_o));
  assign rpt_zero_o   = (rpt_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      blk_q <= '0; blk_start_q <= '0;
      buf_q <= '0; buf_len_q   <= '0;
      rpt_q <= '0; sz_q        <= '0;
    end else if (load_i) begin
      blk_q <= blk_i;    blk_start_q <= blk_i;
      buf_q <= buf_len_i; buf_len_q  <= buf_len_i;
      rpt_q <= rpt_i;    sz_q        <= src_size_i;
    end else if (beat_i) begin
      if (blk_rl_i) begin
        blk_q <= blk_start_q;
        rpt_q <= rpt_q - 1'b1;
        buf_q <= buf_len_q;
      end else begin
        blk_q <= blk_q - CW'(beat_bytes_o);
        buf_q <= buf_rl_i ? buf_len_q : buf_q - LW'(beat_bytes_o);
      end
    end
  end

  // a completing beat never moves more bytes than the block holds
  assert_no_overrun_R10: assert property (@(posedge clk) disable iff (!rst_n)
    beat_i |-> (blk_q >= CW'(beat_bytes_o)) && (beat_bytes_o != 4'd0));

endmodule

// File: rtl/dma_chan_seq.sv
`timescale 1ns/1ps
module dma_chan_seq
  import dma_seq_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 64,
  parameter int CW = 17,
  parameter int RW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          arm_i,
  input  logic [31:0]   cfg_i,
  input  logic [1:0]    prio_i,
  input  logic [AW-1:0] src_i,
  input  logic [AW-1:0] dst_i,
  input  logic [CW-1:0] blk_bytes_i,
  input  logic [RW-1:0] rpt_i,
  input  logic          ack_by_write_i,
  input  logic [AW-1:0] ack_addr_i,
  input  logic [31:0]   ack_val_i,
  input  logic          dreq_i,
  output logic          mem_req_o,
  output logic          mem_we_o,
  output logic [AW-1:0] mem_addr_o,
  output logic [3:0]    mem_bytes_o,
  output logic [DW-1:0] mem_wdata_o,
  input  logic [DW-1:0] mem_rdata_i,
  input  logic          mem_ready_i,
  output logic          busy_o,
  output logic          armed_o,
  output logic [1:0]    prio_o,
  output logic          hw_ack_o,
  output logic          buf_done_o,
  output logic          blk_done_o,
  output logic          xfer_done_o,
  output logic          err_o
);

  localparam int LW = 8;
  localparam int NPTR = 2;

  // configuration fields
  logic [1:0] f_trig;
  logic [7:0] f_len;
  logic       unused_cfg;
  assign f_trig     = cfg_i[29:28];
  assign f_len      = cfg_i[25:18];
  assign unused_cfg = ^{cfg_i[31:30], cfg_i[27:26], cfg_i[17:12], cfg_i[7:4]};

  seq_st_e       st_q, st_d;
  logic [1:0]    trig_q;
  logic          ackw_q, fin_q, err_q;
  logic [AW-1:0] ack_addr_q;
  logic [31:0]   ack_val_q;
  logic [DW-1:0] rd_data_q;
  logic          hw_ack_q, buf_done_q, blk_done_q, xfer_done_q;
  logic [1:0]    prio_q;

  // named internal events
  logic idle_ok, cfg_bad, arm_ok, beat_fire, rpt_go, all_end, req_end;
  logic [3:0] beat_bytes;
  logic buf_end, blk_end, rpt_zero;

  assign idle_ok   = (st_q == ST_IDLE) || (st_q == ST_ARMED);
  assign cfg_bad   = (f_len == 8'd0) || (f_len > BUF_MAX) ||
                     (f_trig == TRIG_LL) || (blk_bytes_i == '0);
  assign arm_ok    = arm_i && idle_ok && !err_q && !cfg_bad;
  assign beat_fire = (st_q == ST_WR) && mem_ready_i;
  assign rpt_go    = (trig_q == TRIG_RPT) && !rpt_zero;
  assign all_end   = blk_end && !rpt_go;
  assign req_end   = all_end || ((trig_q == TRIG_BUF) && buf_end);

  // source (0) and destination (1) pointers
  logic [AW-1:0] p_start [NPTR];
  logic [1:0]    p_mode  [NPTR];
  logic [1:0]    p_size  [NPTR];
  logic [AW-1:0] p_val   [NPTR];
  assign p_start[0] = src_i;       assign p_start[1] = dst_i;
  assign p_mode[0]  = cfg_i[1:0];  assign p_mode[1]  = cfg_i[3:2];
  assign p_size[0]  = cfg_i[9:8];  assign p_size[1]  = cfg_i[11:10];

  for (genvar g = 0; g < NPTR; g++) begin : g_ptr
    dma_ptr_unit #(.AW(AW)) u_ptr (
      .clk(clk), .rst_n(rst_n), .load_i(arm_ok), .start_i(p_start[g]),
      .mode_i(p_mode[g]), .size_i(p_size[g]),
      .rewind_i(beat_fire && blk_end && rpt_go), .step_i(beat_fire),
      .ptr_o(p_val[g]));
  end

  dma_len_ctrl #(.CW(CW), .RW(RW), .LW(LW)) u_len (
    .clk(clk), .rst_n(rst_n), .load_i(arm_ok), .blk_i(blk_bytes_i),
    .buf_len_i(f_len), .rpt_i(rpt_i), .src_size_i(cfg_i[9:8]),
    .beat_i(beat_fire), .buf_rl_i(buf_end || blk_end),
    .blk_rl_i(blk_end && rpt_go), .beat_bytes_o(beat_bytes),
    .buf_end_o(buf_end), .blk_end_o(blk_end), .rpt_zero_o(rpt_zero));

  always_comb begin
    st_d = st_q;
    case (st_q)
      ST_IDLE:  if (arm_ok) st_d = ST_ARMED;
      ST_ARMED: if (arm_i) st_d = cfg_bad ? ST_IDLE : ST_ARMED;
                else if (dreq_i) st_d = ST_RD;
      ST_RD:    if (mem_ready_i) st_d = ST_WR;
      ST_WR:    if (mem_ready_i) begin
                  if (!req_end)    st_d = ST_RD;
                  else if (ackw_q) st_d = ST_ACK;
                  else             st_d = all_end ? ST_IDLE : ST_ARMED;
                end
      ST_ACK:   if (mem_ready_i) st_d = fin_q ? ST_IDLE : ST_ARMED;
      default:  st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= ST_IDLE; trig_q <= '0; ackw_q <= 1'b0; fin_q <= 1'b0;
      err_q <= 1'b0; ack_addr_q <= '0; ack_val_q <= '0; rd_data_q <= '0;
      hw_ack_q <= 1'b0; buf_done_q <= 1'b0; blk_done_q <= 1'b0;
      xfer_done_q <= 1'b0; prio_q <= '0;
    end else begin
      st_q        <= st_d;
      hw_ack_q    <= beat_fire && req_end && !ackw_q;
      buf_done_q  <= beat_fire && (buf_end || blk_end);
      blk_done_q  <= beat_fire && blk_end;
      xfer_done_q <= beat_fire && all_end;
      if (arm_i && idle_ok && cfg_bad) err_q <= 1'b1;
      if (arm_ok) begin
        trig_q     <= f_trig;
        ackw_q     <= ack_by_write_i;
        ack_addr_q <= ack_addr_i;
        ack_val_q  <= ack_val_i;
        prio_q     <= prio_i;
      end
      if (st_q == ST_RD && mem_ready_i) rd_data_q <= mem_rdata_i;
      if (beat_fire && req_end) fin_q <= all_end;
    end
  end

  // master port
  assign mem_req_o   = (st_q == ST_RD) || (st_q == ST_WR) || (st_q == ST_ACK);
  assign mem_we_o    = (st_q == ST_WR) || (st_q == ST_ACK);
  assign mem_addr_o  = (st_q == ST_ACK) ? ack_addr_q :
                       (st_q == ST_WR)  ? p_val[1] : p_val[0];
  assign mem_bytes_o = (st_q == ST_ACK) ? 4'd4 : beat_bytes;
  assign mem_wdata_o = (st_q == ST_ACK) ? DW'(ack_val_q) : rd_data_q;

  assign busy_o      = mem_req_o;
  assign armed_o     = (st_q != ST_IDLE);
  assign prio_o      = prio_q;
  assign hw_ack_o    = hw_ack_q;
  assign buf_done_o  = buf_done_q;
  assign blk_done_o  = blk_done_q;
  assign xfer_done_o = xfer_done_q;
  assign err_o       = err_q;

  assert_err_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |=> err_o);
  assert_err_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |-> !mem_req_o);
  assert_xfer_with_blk_R12: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_done_o |-> blk_done_o);
  assert_xfer_single_R12: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_done_o |=> !xfer_done_o);
  assert_req_hold_R13: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_o && !mem_ready_i) |=> mem_req_o && $stable(mem_addr_o)
                                    && $stable(mem_bytes_o));
  assert_busy_ack_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(busy_o) && ackw_q) |-> ($past(st_q) == ST_ACK));
  assert_prio_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |=> $stable(prio_o));

endmodule

// File: tb/dma_chan_seq_tb_top.sv
`timescale 1ns/1ps
module dma_chan_seq_tb_top;

  localparam int AW = 32, DW = 64, CW = 12, RW = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic arm = 0, ackw = 0, dreq = 0;
  logic [31:0] cfg = '0, ack_addr = '0, ack_val = '0, src = '0, dst = '0;
  logic [1:0]  prio = '0;
  logic [CW-1:0] blk = '0;
  logic [RW-1:0] rpt = '0;
  logic mem_req, mem_we, mem_ready, busy, armed, hw_ack;
  logic buf_done, blk_done, xfer_done, err;
  logic [AW-1:0] mem_addr;
  logic [3:0] mem_bytes;
  logic [DW-1:0] mem_wdata, mem_rdata;
  logic [1:0] prio_out;
  logic stall_en = 0, stall_ph = 0;

  always #2.5 clk = ~clk;
  always @(posedge clk) stall_ph <= ~stall_ph;
  assign mem_ready = !(stall_en && stall_ph);
  assign mem_rdata = {mem_addr, ~mem_addr};

  dma_chan_seq #(.AW(AW), .DW(DW), .CW(CW), .RW(RW)) dut_i (
    .clk(clk), .rst_n(rst_n), .arm_i(arm), .cfg_i(cfg), .prio_i(prio),
    .src_i(src), .dst_i(dst), .blk_bytes_i(blk), .rpt_i(rpt),
    .ack_by_write_i(ackw), .ack_addr_i(ack_addr), .ack_val_i(ack_val),
    .dreq_i(dreq), .mem_req_o(mem_req), .mem_we_o(mem_we),
    .mem_addr_o(mem_addr), .mem_bytes_o(mem_bytes), .mem_wdata_o(mem_wdata),
    .mem_rdata_i(mem_rdata), .mem_ready_i(mem_ready), .busy_o(busy),
    .armed_o(armed), .prio_o(prio_out), .hw_ack_o(hw_ack),
    .buf_done_o(buf_done), .blk_done_o(blk_done), .xfer_done_o(xfer_done),
    .err_o(err));

  // write log and pulse counters, sampled away from the active edge
  logic [31:0] lg_addr [0:255];
  logic [3:0]  lg_bytes[0:255];
  logic [63:0] lg_data [0:255];
  logic        lg_busy [0:255];
  int lg_n = 0, c_buf = 0, c_blk = 0, c_xfer = 0, c_hw = 0;
  always @(negedge clk) begin
    if (rst_n && mem_req && mem_we && mem_ready) begin
      if (lg_n < 256) begin
        lg_addr[lg_n] = mem_addr; lg_bytes[lg_n] = mem_bytes;
        lg_data[lg_n] = mem_wdata; lg_busy[lg_n] = busy;
      end
      lg_n++;
    end
    if (buf_done)  c_buf++;
    if (blk_done)  c_blk++;
    if (xfer_done) c_xfer++;
    if (hw_ack)    c_hw++;
  end

  int n_chk = 0, n_fail = 0;
  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // reference model
  logic [31:0] ex_addr [0:255];
  logic [3:0]  ex_bytes[0:255];
  logic [63:0] ex_data [0:255];
  logic        ex_ack  [0:255];
  int ex_n, e_buf, e_blk, e_xfer, e_hw;
  logic [31:0] m_src0, m_dst0, m_src, m_dst;
  int m_blk0, m_blk, m_rpt, m_len;
  logic [1:0] m_smode, m_dmode, m_ssz, m_dsz, m_trig;

  function automatic logic [31:0] mv(input logic [31:0] p, input logic [1:0] mode, input logic [1:0] sz);
    int st = 1 << sz;
    if (mode == 2'b10) return p + st;
    if (mode == 2'b11) return p - st;
    return p;
  endfunction

  function automatic logic [31:0] mk_cfg(input logic [1:0] sm, dm, ssz, dsz, trig, input int len);
    logic [31:0] c = '0;
    c[1:0] = sm; c[3:2] = dm; c[9:8] = ssz; c[11:10] = dsz;
    c[25:18] = len[7:0]; c[29:28] = trig;
    return c;
  endfunction

  task automatic push(input logic [31:0] a, input int b, input logic [63:0] d, input logic k);
    ex_addr[ex_n] = a; ex_bytes[ex_n] = b[3:0]; ex_data[ex_n] = d; ex_ack[ex_n] = k; ex_n++;
  endtask

  task automatic model_req();
    int left = m_len;
    int b;
    forever begin
      b = 1 << m_ssz;
      if (left < b) b = left;
      if (m_blk < b) b = m_blk;
      push(m_dst, b, {m_src, ~m_src}, 1'b0);
      m_src = mv(m_src, m_smode, m_ssz);
      m_dst = mv(m_dst, m_dmode, m_dsz);
      m_blk -= b; left -= b;
      if (m_blk == 0) begin
        e_buf++; e_blk++;
        if (m_trig == 2'b10 && m_rpt > 0) begin
          m_rpt--; m_src = m_src0; m_dst = m_dst0; m_blk = m_blk0; left = m_len;
        end else begin
          e_xfer++;
          break;
        end
      end else if (left == 0) begin
        e_buf++; left = m_len;
        if (m_trig == 2'b00) break;
      end
    end
    if (ackw) push(ack_addr, 4, {32'd0, ack_val}, 1'b1);
    else e_hw++;
  endtask

  // stimulus helpers
  task automatic do_reset();
    rst_n = 0; arm = 0; dreq = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
  endtask

  task automatic arm_ch(input logic [31:0] c, input logic [31:0] s, d, input int bl, rp);
    @(negedge clk);
    cfg = c; src = s; dst = d; blk = CW'(bl); rpt = RW'(rp); arm = 1;
    @(negedge clk);
    arm = 0;
    m_smode = c[1:0]; m_dmode = c[3:2]; m_ssz = c[9:8]; m_dsz = c[11:10];
    m_len = int'(c[25:18]); m_trig = c[29:28];
    m_src0 = s; m_dst0 = d; m_src = s; m_dst = d; m_blk0 = bl; m_blk = bl; m_rpt = rp;
  endtask

  task automatic wait_idle();
    int k = 0;
    while (busy && k < 5000) begin @(negedge clk); k++; end
    if (busy) begin n_fail++; $display("FAIL watchdog: busy stuck"); end
    @(negedge clk);
  endtask

  task automatic do_req(input bit extra);
    @(negedge clk); dreq = 1;
    @(negedge clk); dreq = 0;
    if (extra) begin @(negedge clk); dreq = 1; @(negedge clk); dreq = 0; end
    wait_idle();
  endtask

  int base, b_buf, b_blk, b_xfer, b_hw;
  task automatic begin_case();
    base = lg_n; ex_n = 0; e_buf = 0; e_blk = 0; e_xfer = 0; e_hw = 0;
    b_buf = c_buf; b_blk = c_blk; b_xfer = c_xfer; b_hw = c_hw;
  endtask

  task automatic cmp_log(input string tag);
    chk({tag, " write count"}, 64'(lg_n - base), 64'(ex_n));
    for (int i = 0; i < ex_n && i < lg_n - base; i++) begin
      chk({tag, " addr"},  64'(lg_addr[base+i]),  64'(ex_addr[i]));
      chk({tag, " bytes"}, 64'(lg_bytes[base+i]), 64'(ex_bytes[i]));
      chk({tag, " data"},  lg_data[base+i], ex_data[i]);
      if (ex_ack[i]) chk("R9 busy during ack write", 64'(lg_busy[base+i]), 64'd1);
    end
  endtask

  task automatic cmp_pulses(input string tag);
    chk({tag, " R3 buf pulses"},  64'(c_buf - b_buf),   64'(e_buf));
    chk({tag, " R10 blk pulses"}, 64'(c_blk - b_blk),   64'(e_blk));
    chk({tag, " R12 xfer pulses"},64'(c_xfer - b_xfer), 64'(e_xfer));
    chk({tag, " R8 hw ack"},      64'(c_hw - b_hw),     64'(e_hw));
  endtask

  // scenarios
  task automatic t_reset();
    do_reset();
    chk("reset busy", 64'(busy), 0);
    chk("reset mem_req", 64'(mem_req), 0);
    chk("reset armed", 64'(armed), 0);
    chk("R7 reset err", 64'(err), 0);
  endtask

  task automatic t_block();
    begin_case();
    ackw = 0; prio = 2'b10;
    arm_ch(mk_cfg(2'b10, 2'b10, 2'b10, 2'b10, 2'b01, 8), 32'h1000, 32'h2000, 16, 0);
    chk("R11 prio latched", 64'(prio_out), 64'h2);
    model_req(); do_req(0);
    cmp_log("R5 R1 R2 block");
    cmp_pulses("R5");
    chk("R12 disarmed after done", 64'(armed), 0);
    begin_case(); do_req(0);
    cmp_log("R12 request after done ignored");
  endtask

  task automatic t_buffer();
    begin_case();
    ackw = 1; ack_addr = 32'h4000_0010; ack_val = 32'h0000_005A; prio = 2'b01;
    arm_ch(mk_cfg(2'b11, 2'b00, 2'b01, 2'b00, 2'b00, 4), 32'h3000, 32'h5000, 10, 0);
    model_req(); do_req(1);
    cmp_log("R4 R9 first buffer, extra request ignored");
    chk("R4 still armed", 64'(armed), 1);
    model_req(); do_req(0);
    model_req(); do_req(0);
    cmp_log("R4 R8 R10 buffers");
    cmp_pulses("R4");
    chk("R11 prio", 64'(prio_out), 64'h1);
  endtask

  task automatic t_repeat();
    begin_case();
    ackw = 0; stall_en = 1;
    arm_ch(mk_cfg(2'b10, 2'b11, 2'b11, 2'b10, 2'b10, 16), 32'h0800, 32'h9000, 12, 2);
    model_req(); do_req(0);
    stall_en = 0;
    cmp_log("R6 R13 R10 repeat with stalls");
    cmp_pulses("R6");
  endtask

  task automatic t_err(input string tag, input logic [31:0] c, input int bl);
    do_reset();
    begin_case();
    arm_ch(c, 32'h100, 32'h200, bl, 0);
    chk({tag, " R7 err set"}, 64'(err), 1);
    chk({tag, " R7 not armed"}, 64'(armed), 0);
    do_req(0);
    repeat (3) @(negedge clk);
    chk({tag, " R7 no access"}, 64'(lg_n - base), 0);
    arm_ch(mk_cfg(2'b10, 2'b10, 2'b00, 2'b00, 2'b01, 4), 32'h100, 32'h200, 4, 0);
    chk({tag, " R7 err sticky"}, 64'(err), 1);
  endtask

  initial begin
    t_reset();
    t_block();
    t_buffer();
    t_repeat();
    t_err("trig11", mk_cfg(2'b10, 2'b10, 2'b00, 2'b00, 2'b11, 4), 8);
    t_err("len0",   mk_cfg(2'b10, 2'b10, 2'b00, 2'b00, 2'b01, 0), 8);
    t_err("len129", mk_cfg(2'b10, 2'b10, 2'b00, 2'b00, 2'b01, 129), 8);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(5.0 * 150000);
    n_fail++;
    $display("FAIL watchdog: run did not finish");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

endmodule